// File: doc/BRIEF.md
# Field-Adaptive Luma Black/White Stretch

This block sits in a video pixel pipeline and widens the contrast of a YCbCr stream at its dark and bright ends. While a field streams through, it keeps the largest luma, the smallest luma, the luma sum and the pixel count. At each field-start pulse, the maximum and minimum of the field that just ended are copied into shadow registers. A serial divider then turns the sum and count into the average picture level (APL). The pixels of the new field are remapped using those shadow values.

Luma below a host-set low knee is pushed downward and luma above a high knee is pushed upward. Each push is proportional to the distance from the knee. The low-side push applies only when the previous field actually reached below the low knee. The high-side push applies only when the previous field reached above the high knee. The APL selects which side works at full strength: a dark picture halves the low-side gain, and a bright picture halves the high-side gain. Chroma is never altered. It travels through the same two register stages as luma, so the three components leave together.

The host programs knees, gains, the APL split point and two enables through a small write-only register port. These settings must be written before the enables are set.

Top module: `luma_stretch`

## Requirements
- R1: A pixel presented with `i_valid` high appears on the outputs exactly two clock cycles later with `o_valid` high, in input order. `o_cb` and `o_cr` equal the input chroma of that pixel unchanged.
- R2: With both enable bits cleared, `o_y` equals the input luma, with the same two-cycle latency.
- R3: Luma y with low_knee <= y <= high_knee leaves unchanged.
- R4: If the low enable is set, y < low_knee, and the shadow minimum is below low_knee, then out = y - ((low_knee - y) * g_lo >> 4), limited at 0. Here g_lo is the low gain, halved (shift right by one) when the shadow APL is below the APL split. The low side wins if both sides qualify.
- R5: If the high enable is set, y > high_knee, and the shadow maximum is above high_knee, then out = y + ((y - high_knee) * g_hi >> 4), limited at 1023. Here g_hi is the high gain, halved when the shadow APL is at or above the APL split.
- R6: A field-start pulse copies the maximum and minimum luma of all valid pixels since the previous pulse into the shadows. A pixel that is valid in the same cycle as the pulse belongs to the new field and is itself processed with the old shadows.
- R7: The shadow APL becomes floor(sum / count) of the previous field no more than 12 cycles after the pulse. Pixels in that window use the older APL.
- R8: A field-start pulse that ends a field with no valid pixels leaves all shadows unchanged.
- R9: A write (`wr_en` high) with address 0 sets the low knee, 1 the high knee, 2 the low gain (6 bits, 4 fractional), 3 the high gain, 4 the APL split, and 5 the enables (bit 0 low side, bit 1 high side). The write takes effect from the next cycle. Addresses 6 and 7 change nothing.
- R10: Reset values are: low knee 0, high knee 1023, both gains 0, APL split 512, enables 0, shadow maximum 1023, shadow minimum 0, shadow APL 512. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Input pixel qualifier |
| i_field_start | input | 1 | One-cycle pulse opening a new field |
| i_y | input | 10 | Input luma |
| i_cb | input | 10 | Input blue-difference chroma |
| i_cr | input | 10 | Input red-difference chroma |
| wr_en | input | 1 | Setting register write strobe |
| wr_addr | input | 3 | Setting register address |
| wr_data | input | 10 | Setting register write data |
| o_valid | output | 1 | Output pixel qualifier |
| o_y | output | 10 | Stretched luma |
| o_cb | output | 10 | Delayed blue-difference chroma |
| o_cr | output | 10 | Delayed red-difference chroma |

## Verification
A corrupted pipeline register shows within two cycles, as luma or chroma that is missing, shifted by a pixel, or wrong. A wrong statistics accumulator stays hidden until the next field-start pulse. After that it shows only in the stretched regions, where the gating of a side or the choice of halved gain flips. For this reason the stimulus arranges fields whose minimum, maximum and APL sit on deliberate sides of the knees and the split. A divider fault shows up to twelve cycles after the pulse, and only as a factor of two on one side's gain.

// File: rtl/luma_stretch_pkg.sv
package luma_stretch_pkg;

  typedef enum logic [1:0] {
    SEG_MID   = 2'd0,
    SEG_BLACK = 2'd1,
    SEG_WHITE = 2'd2
  } seg_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_KNEE_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] A_KNEE_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_GAIN_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_GAIN_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_APL_SPLT = 3'd4;
  localparam logic [ADDR_W-1:0] A_ENABLES  = 3'd5;

endpackage

// File: rtl/luma_stretch_regs.sv
module luma_stretch_regs
  import luma_stretch_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] knee_lo,
  output logic [DATA_W-1:0] knee_hi,
  output logic [GAIN_W-1:0] gain_lo,
  output logic [GAIN_W-1:0] gain_hi,
  output logic [DATA_W-1:0] apl_split,
  output logic              en_lo,
  output logic              en_hi
);

  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic ld_klo, ld_khi, ld_glo, ld_ghi, ld_split, ld_en;

  always_comb begin
    ld_klo   = wr_en && (wr_addr == A_KNEE_LO);
    ld_khi   = wr_en && (wr_addr == A_KNEE_HI);
    ld_glo   = wr_en && (wr_addr == A_GAIN_LO);
    ld_ghi   = wr_en && (wr_addr == A_GAIN_HI);
    ld_split = wr_en && (wr_addr == A_APL_SPLT);
    ld_en    = wr_en && (wr_addr == A_ENABLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      knee_lo   <= '0;
      knee_hi   <= '1;
      gain_lo   <= '0;
      gain_hi   <= '0;
      apl_split <= MID_CODE;
      en_lo     <= 1'b0;
      en_hi     <= 1'b0;
    end else begin
      if (ld_klo)   knee_lo   <= wr_data;
      if (ld_khi)   knee_hi   <= wr_data;
      if (ld_glo)   gain_lo   <= wr_data[GAIN_W-1:0];
      if (ld_ghi)   gain_hi   <= wr_data[GAIN_W-1:0];
      if (ld_split) apl_split <= wr_data;
      if (ld_en) begin
        en_lo <= wr_data[0];
        en_hi <= wr_data[1];
      end
    end
  end

endmodule

// File: rtl/luma_stretch_stats.sv
module luma_stretch_stats #(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic              i_field_start,
  input  logic [DATA_W-1:0] i_y,
  output logic [DATA_W-1:0] sh_max,
  output logic [DATA_W-1:0] sh_min,
  output logic [DATA_W-1:0] sh_apl
);

  localparam int SUM_W = DATA_W + CNT_W;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0]  IDX_TOP  = IDX_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  // field accumulators
  logic [DATA_W-1:0] acc_max, acc_min, acc_max_d, acc_min_d;
  logic [SUM_W-1:0]  acc_sum, acc_sum_d;
  logic [CNT_W-1:0]  acc_cnt, acc_cnt_d;
  logic              acc_en;

  // serial divider
  logic              div_busy, div_busy_d;
  logic [IDX_W-1:0]  div_idx, div_idx_d;
  logic [CNT_W-1:0]  div_rem, div_rem_d;
  logic [SUM_W-1:0]  div_num, div_num_d;
  logic [CNT_W-1:0]  div_den, div_den_d;
  logic [DATA_W-1:0] div_q, div_q_d;
  logic [CNT_W:0]    trial, trial_diff;
  logic              trial_ge;
  logic              latch_en, apl_en;
  logic [DATA_W-1:0] apl_d;

  always_comb begin
    acc_max_d = i_field_start ? '0 : acc_max;
    acc_min_d = i_field_start ? '1 : acc_min;
    acc_sum_d = i_field_start ? '0 : acc_sum;
    acc_cnt_d = i_field_start ? '0 : acc_cnt;
    if (i_valid) begin
      if (i_y > acc_max_d) acc_max_d = i_y;
      if (i_y < acc_min_d) acc_min_d = i_y;
      if (acc_cnt_d != '1) begin
        acc_cnt_d = acc_cnt_d + 1'b1;
        acc_sum_d = acc_sum_d + SUM_W'(i_y);
      end
    end
    acc_en   = i_field_start || i_valid;
    latch_en = i_field_start && (acc_cnt != '0);
  end

  always_comb begin
    trial      = {div_rem, div_num[div_idx]};
    trial_diff = trial - {1'b0, div_den};
    trial_ge   = (trial >= {1'b0, div_den});
    div_q_d    = div_q;
    div_q_d[div_idx] = trial_ge;
    div_rem_d  = trial_ge ? trial_diff[CNT_W-1:0] : trial[CNT_W-1:0];
    div_idx_d  = div_idx - 1'b1;
    div_busy_d = div_busy && (div_idx != '0);
    div_num_d  = div_num;
    div_den_d  = div_den;
    apl_en     = div_busy && (div_idx == '0) && !latch_en;
    apl_d      = div_q_d;
    if (latch_en) begin
      div_num_d  = acc_sum;
      div_den_d  = acc_cnt;
      div_rem_d  = acc_sum[SUM_W-1:DATA_W];
      div_idx_d  = IDX_TOP;
      div_q_d    = '0;
      div_busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_max <= '0;
      acc_min <= '1;
      acc_sum <= '0;
      acc_cnt <= '0;
    end else if (acc_en) begin
      acc_max <= acc_max_d;
      acc_min <= acc_min_d;
      acc_sum <= acc_sum_d;
      acc_cnt <= acc_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_max <= '1;
      sh_min <= '0;
    end else if (latch_en) begin
      sh_max <= acc_max;
      sh_min <= acc_min;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_busy <= 1'b0;
      div_idx  <= '0;
      div_rem  <= '0;
      div_num  <= '0;
      div_den  <= '0;
      div_q    <= '0;
    end else if (div_busy || latch_en) begin
      div_busy <= div_busy_d;
      div_idx  <= div_idx_d;
      div_rem  <= div_rem_d;
      div_num  <= div_num_d;
      div_den  <= div_den_d;
      div_q    <= div_q_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_apl <= MID_CODE;
    end else if (apl_en) begin
      sh_apl <= apl_d;
    end
  end

endmodule

// File: rtl/luma_stretch_map.sv
module luma_stretch_map
  import luma_stretch_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int GAIN_W    = 6,
  parameter int GAIN_FRAC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic [DATA_W-1:0] i_y,
  input  logic [DATA_W-1:0] i_cb,
  input  logic [DATA_W-1:0] i_cr,
  input  logic [DATA_W-1:0] knee_lo,
  input  logic [DATA_W-1:0] knee_hi,
  input  logic [GAIN_W-1:0] gain_lo,
  input  logic [GAIN_W-1:0] gain_hi,
  input  logic [DATA_W-1:0] apl_split,
  input  logic              en_lo,
  input  logic              en_hi,
  input  logic [DATA_W-1:0] sh_max,
  input  logic [DATA_W-1:0] sh_min,
  input  logic [DATA_W-1:0] sh_apl,
  output logic              o_valid,
  output logic [DATA_W-1:0] o_y,
  output logic [DATA_W-1:0] o_cb,
  output logic [DATA_W-1:0] o_cr
);

  localparam int PROD_W = DATA_W + GAIN_W;
  localparam logic [PROD_W:0] Y_TOP = (PROD_W+1)'({DATA_W{1'b1}});

  // stage 1: segment decision
  logic              apl_low;
  logic [GAIN_W-1:0] g_lo_eff, g_hi_eff;
  seg_e              seg_d, s1_seg;
  logic [DATA_W-1:0] dist_d, s1_dist;
  logic [GAIN_W-1:0] gain_d, s1_gain;
  logic              s1_valid;
  logic [DATA_W-1:0] s1_y, s1_cb, s1_cr;

  always_comb begin
    apl_low  = (sh_apl < apl_split);
    g_lo_eff = apl_low ? (gain_lo >> 1) : gain_lo;
    g_hi_eff = apl_low ? gain_hi : (gain_hi >> 1);
    seg_d    = SEG_MID;
    dist_d   = '0;
    gain_d   = '0;
    if (en_lo && (i_y < knee_lo) && (sh_min < knee_lo)) begin
      seg_d  = SEG_BLACK;
      dist_d = knee_lo - i_y;
      gain_d = g_lo_eff;
    end else if (en_hi && (i_y > knee_hi) && (sh_max > knee_hi)) begin
      seg_d  = SEG_WHITE;
      dist_d = i_y - knee_hi;
      gain_d = g_hi_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= i_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_y    <= '0;
      s1_cb   <= '0;
      s1_cr   <= '0;
      s1_seg  <= SEG_MID;
      s1_dist <= '0;
      s1_gain <= '0;
    end else if (i_valid) begin
      s1_y    <= i_y;
      s1_cb   <= i_cb;
      s1_cr   <= i_cr;
      s1_seg  <= seg_d;
      s1_dist <= dist_d;
      s1_gain <= gain_d;
    end
  end

  // stage 2: scaled offset and limiting
  logic [PROD_W-1:0] prod, extra, y_wide;
  logic [PROD_W:0]   up_sum;
  logic [DATA_W-1:0] y_d;

  always_comb begin
    prod   = PROD_W'(s1_dist) * PROD_W'(s1_gain);
    extra  = prod >> GAIN_FRAC;
    y_wide = PROD_W'(s1_y);
    up_sum = (PROD_W+1)'(y_wide) + (PROD_W+1)'(extra);
    case (s1_seg)
      SEG_BLACK: y_d = (extra >= y_wide) ? '0 : DATA_W'(y_wide - extra);
      SEG_WHITE: y_d = (up_sum > Y_TOP) ? '1 : DATA_W'(up_sum);
      default:   y_d = s1_y;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
    end else begin
      o_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_y  <= '0;
      o_cb <= '0;
      o_cr <= '0;
    end else if (s1_valid) begin
      o_y  <= y_d;
      o_cb <= s1_cb;
      o_cr <= s1_cr;
    end
  end

endmodule

// File: rtl/luma_stretch.sv
module luma_stretch
  import luma_stretch_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int GAIN_W    = 6,
  parameter int GAIN_FRAC = 4,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic              i_field_start,
  input  logic [DATA_W-1:0] i_y,
  input  logic [DATA_W-1:0] i_cb,
  input  logic [DATA_W-1:0] i_cr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              o_valid,
  output logic [DATA_W-1:0] o_y,
  output logic [DATA_W-1:0] o_cb,
  output logic [DATA_W-1:0] o_cr
);

  logic [DATA_W-1:0] cfg_knee_lo, cfg_knee_hi, cfg_apl_split;
  logic [GAIN_W-1:0] cfg_gain_lo, cfg_gain_hi;
  logic              cfg_en_lo, cfg_en_hi;
  logic [DATA_W-1:0] sh_max, sh_min, sh_apl;

  luma_stretch_regs #(
    .DATA_W (DATA_W),
    .GAIN_W (GAIN_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .knee_lo   (cfg_knee_lo),
    .knee_hi   (cfg_knee_hi),
    .gain_lo   (cfg_gain_lo),
    .gain_hi   (cfg_gain_hi),
    .apl_split (cfg_apl_split),
    .en_lo     (cfg_en_lo),
    .en_hi     (cfg_en_hi)
  );

  luma_stretch_stats #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_stats (
    .clk           (clk),
    .rst_n         (rst_n),
    .i_valid       (i_valid),
    .i_field_start (i_field_start),
    .i_y           (i_y),
    .sh_max        (sh_max),
    .sh_min        (sh_min),
    .sh_apl        (sh_apl)
  );

  luma_stretch_map #(
    .DATA_W    (DATA_W),
    .GAIN_W    (GAIN_W),
    .GAIN_FRAC (GAIN_FRAC)
  ) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .i_valid   (i_valid),
    .i_y       (i_y),
    .i_cb      (i_cb),
    .i_cr      (i_cr),
    .knee_lo   (cfg_knee_lo),
    .knee_hi   (cfg_knee_hi),
    .gain_lo   (cfg_gain_lo),
    .gain_hi   (cfg_gain_hi),
    .apl_split (cfg_apl_split),
    .en_lo     (cfg_en_lo),
    .en_hi     (cfg_en_hi),
    .sh_max    (sh_max),
    .sh_min    (sh_min),
    .sh_apl    (sh_apl),
    .o_valid   (o_valid),
    .o_y       (o_y),
    .o_cb      (o_cb),
    .o_cr      (o_cr)
  );

endmodule

// File: rtl/luma_stretch_chk.sv
module luma_stretch_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              i_valid,
  input logic [DATA_W-1:0] i_y,
  input logic [DATA_W-1:0] i_cb,
  input logic [DATA_W-1:0] i_cr,
  input logic              o_valid,
  input logic [DATA_W-1:0] o_y,
  input logic [DATA_W-1:0] o_cb,
  input logic [DATA_W-1:0] o_cr,
  input logic [DATA_W-1:0] knee_lo,
  input logic [DATA_W-1:0] knee_hi,
  input logic              en_lo,
  input logic              en_hi,
  input logic [DATA_W-1:0] sh_max,
  input logic [DATA_W-1:0] sh_min
);

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid == $past(i_valid, 2)); // R1

  AST_CHROMA_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_cb == $past(i_cb, 2)) && (o_cr == $past(i_cr, 2))); // R1

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !$past(en_lo, 2) && !$past(en_hi, 2)) |-> o_y == $past(i_y, 2)); // R2

  AST_MID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && ($past(i_y, 2) >= $past(knee_lo, 2)) && ($past(i_y, 2) <= $past(knee_hi, 2)))
      |-> o_y == $past(i_y, 2)); // R3

  AST_BLACK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && ($past(knee_lo, 2) <= $past(knee_hi, 2)) && ($past(i_y, 2) < $past(knee_lo, 2)))
      |-> o_y <= $past(i_y, 2)); // R4

  AST_WHITE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && ($past(knee_lo, 2) <= $past(knee_hi, 2)) && ($past(i_y, 2) > $past(knee_hi, 2)))
      |-> o_y >= $past(i_y, 2)); // R5

  AST_SHADOW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    sh_min <= sh_max); // R6

endmodule

bind luma_stretch luma_stretch_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .i_valid (i_valid),
  .i_y     (i_y),
  .i_cb    (i_cb),
  .i_cr    (i_cr),
  .o_valid (o_valid),
  .o_y     (o_y),
  .o_cb    (o_cb),
  .o_cr    (o_cr),
  .knee_lo (cfg_knee_lo),
  .knee_hi (cfg_knee_hi),
  .en_lo   (cfg_en_lo),
  .en_hi   (cfg_en_hi),
  .sh_max  (sh_max),
  .sh_min  (sh_min)
);

// File: tb/luma_stretch_bench.sv
module luma_stretch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 10;
  localparam int YMAX = 1023;
  localparam int SETTLE = DW + 8;
  localparam int QD   = 4096;

  logic          clk, rst_n;
  logic          i_valid, i_field_start, wr_en;
  logic [DW-1:0] i_y, i_cb, i_cr, wr_data;
  logic [2:0]    wr_addr;
  logic          o_valid;
  logic [DW-1:0] o_y, o_cb, o_cr;

  luma_stretch u_luma_stretch (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_field_start(i_field_start),
    .i_y(i_y), .i_cb(i_cb), .i_cr(i_cr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .o_valid(o_valid), .o_y(o_y), .o_cb(o_cb), .o_cr(o_cr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // model state
  int m_klo = 0, m_khi = YMAX, m_glo = 0, m_ghi = 0, m_split = 512;
  bit m_enlo = 0, m_enhi = 0;
  int s_max = YMAX, s_min = 0, s_apl = 512;
  int f_max = 0, f_min = YMAX, f_sum = 0, f_cnt = 0;
  string phase_tag = "";

  int    exp_y [0:QD-1];
  int    exp_cb[0:QD-1];
  int    exp_cr[0:QD-1];
  int    exp_cy[0:QD-1];
  string exp_tag[0:QD-1];
  int wr_i = 0, rd_i = 0;

  task automatic check(int act, int expv, string tag, string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int model_y(int y, output string tag);
    bit apl_low;
    int glo, ghi, ext, r;
    apl_low = (s_apl < m_split);
    glo = apl_low ? m_glo / 2 : m_glo;
    ghi = apl_low ? m_ghi : m_ghi / 2;
    if (m_enlo && y < m_klo && s_min < m_klo) begin
      tag = "R4";
      ext = ((m_klo - y) * glo) >> 4;
      r = (y > ext) ? y - ext : 0;
    end else if (m_enhi && y > m_khi && s_max > m_khi) begin
      tag = "R5";
      ext = ((y - m_khi) * ghi) >> 4;
      r = (y + ext > YMAX) ? YMAX : y + ext;
    end else begin
      r = y;
      if (!m_enlo && !m_enhi) tag = "R2";
      else if (y >= m_klo && y <= m_khi) tag = "R3";
      else tag = "R6";
    end
    if (phase_tag != "") tag = phase_tag;
    return r;
  endfunction

  task automatic model_field_start();
    if (f_cnt > 0) begin
      s_max = f_max; s_min = f_min; s_apl = f_sum / f_cnt;
    end
    f_max = 0; f_min = YMAX; f_sum = 0; f_cnt = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      i_valid = 1'b0; i_field_start = 1'b0;
    end
  endtask

  task automatic drive_pix(int y, int cb, int cr, bit fs);
    string t;
    int e;
    @(negedge clk);
    i_valid = 1'b1; i_field_start = fs;
    i_y = DW'(y); i_cb = DW'(cb); i_cr = DW'(cr);
    e = model_y(y, t);
    exp_y[wr_i % QD] = e; exp_cb[wr_i % QD] = cb; exp_cr[wr_i % QD] = cr;
    exp_cy[wr_i % QD] = cyc; exp_tag[wr_i % QD] = t;
    wr_i++;
    if (fs) model_field_start();
    if (y > f_max) f_max = y;
    if (y < f_min) f_min = y;
    f_sum += y; f_cnt++;
  endtask

  task automatic field_start();
    @(negedge clk);
    i_valid = 1'b0; i_field_start = 1'b1;
    model_field_start();
    idle(SETTLE);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = DW'(d);
    case (a)
      0: m_klo = d;
      1: m_khi = d;
      2: m_glo = d % 64;
      3: m_ghi = d % 64;
      4: m_split = d;
      5: begin m_enlo = d[0]; m_enhi = d[1]; end
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && o_valid) begin
      if (rd_i >= wr_i) begin
        check(1, 0, "R1", "unexpected o_valid");
      end else begin
        check(int'(o_y), exp_y[rd_i % QD], exp_tag[rd_i % QD], "o_y");
        check(int'(o_cb), exp_cb[rd_i % QD], "R1", "o_cb");
        check(int'(o_cr), exp_cr[rd_i % QD], "R1", "o_cr");
        check(cyc - exp_cy[rd_i % QD], 2, "R1", "latency");
        rd_i++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int mode, n, y;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; i_valid = 1'b0; i_field_start = 1'b0;
    i_y = '0; i_cb = '0; i_cr = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    // R10: outputs quiet during reset
    check(int'(o_valid), 0, "R10", "o_valid in reset");
    check(int'(o_y), 0, "R10", "o_y in reset");
    check(int'(o_cb), 0, "R10", "o_cb in reset");
    check(int'(o_cr), 0, "R10", "o_cr in reset");
    rst_n = 1'b1;
    idle(2);

    // R2 / R10: reset settings, stretch off, pass-through
    field_start();
    drive_pix(5, 11, 22, 0);
    drive_pix(1010, 33, 44, 0);
    for (int k = 0; k < 20; k++) drive_pix($urandom_range(0, YMAX), $urandom_range(0, YMAX), $urandom_range(0, YMAX), 0);
    idle(4);

    // R9: program settings, R3/R4/R5 with limits
    wr(0, 200); wr(1, 800); wr(2, 32); wr(3, 32); wr(4, 512); wr(5, 3);
    wr(7, 0); wr(6, 1023);
    field_start();
    drive_pix(0, 1, 2, 0);
    drive_pix(1, 3, 4, 0);
    drive_pix(199, 5, 6, 0);
    drive_pix(200, 7, 8, 0);
    drive_pix(500, 9, 10, 0);
    drive_pix(800, 11, 12, 0);
    drive_pix(801, 13, 14, 0);
    drive_pix(900, 15, 16, 0);
    drive_pix(1023, 17, 18, 0);
    idle(4);

    // R7: dark APL halves low gain, bright APL halves high gain
    phase_tag = "R7";
    field_start();
    for (int k = 0; k < 8; k++) drive_pix(50, 100, 100, 0);
    drive_pix(950, 100, 100, 0);
    field_start();
    drive_pix(100, 1, 1, 0);
    drive_pix(900, 2, 2, 0);
    for (int k = 0; k < 8; k++) drive_pix(950, 3, 3, 0);
    drive_pix(10, 4, 4, 0);
    field_start();
    drive_pix(100, 5, 5, 0);
    drive_pix(900, 6, 6, 0);
    idle(4);

    // R8: an empty field keeps the shadows
    phase_tag = "";
    field_start();
    for (int k = 0; k < 6; k++) drive_pix(950, 7, 7, 0);
    field_start();
    field_start();
    phase_tag = "R8";
    drive_pix(900, 8, 8, 0);
    drive_pix(120, 9, 9, 0);
    idle(4);

    // R6: pixel together with the pulse joins the new field
    phase_tag = "R6";
    drive_pix(990, 20, 21, 1);
    idle(SETTLE);
    for (int k = 0; k < 6; k++) drive_pix(400 + 40 * k, 22, 23, 0);
    field_start();
    drive_pix(900, 24, 25, 0);
    drive_pix(850, 26, 27, 0);
    idle(4);

    // R9: only the high side enabled
    phase_tag = "R9";
    wr(5, 2);
    drive_pix(100, 30, 31, 0);
    drive_pix(900, 32, 33, 0);
    idle(4);
    phase_tag = "";

    // random fields
    for (int f = 0; f < 12; f++) begin
      if (f % 3 == 0) begin
        wr(0, $urandom_range(0, 600));
        wr(1, $urandom_range(400, YMAX));
        wr(2, $urandom_range(0, 63));
        wr(3, $urandom_range(0, 63));
        wr(4, $urandom_range(100, 900));
        wr(5, $urandom_range(0, 3));
      end
      field_start();
      mode = $urandom_range(0, 2);
      n = $urandom_range(20, 60);
      for (int k = 0; k < n; k++) begin
        case (mode)
          0: y = $urandom_range(0, YMAX);
          1: y = $urandom_range(0, 300);
          default: y = $urandom_range(700, YMAX);
        endcase
        drive_pix(y, $urandom_range(0, YMAX), $urandom_range(0, YMAX), 0);
        if ($urandom_range(0, 3) == 0) idle(1);
      end
      idle(2);
    end

    idle(8);
    check(rd_i, wr_i, "R1", "pixel count out vs in");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule